// File: doc/BRIEF.md
# Four-Bit Accumulator Processor

This block is a small single-accumulator processor for teaching. Its datapath, accumulator and program counter are four bits wide. A sixteen-word memory with eight-bit words holds both the program and its data. Each instruction word carries a four-bit opcode in its upper nibble and a four-bit argument in its lower nibble. The argument is an immediate value, a memory address or a relative branch distance, depending on the opcode. A memory operand is the low nibble of the addressed word.

Every instruction takes two clock cycles. In the first cycle, the fetch phase, the program counter is on the address bus and the addressed word is latched into the opcode and argument registers. The flags are sampled from the committed accumulator at the same edge. In the second cycle, the execute phase, the instruction runs. At the edge that ends this cycle the new program counter, the new accumulator value and any store are committed. The flags therefore describe the accumulator as it stood after the previous instruction, so a branch tests the result of the instruction before it.

Memory is filled through a write port that only acts while reset is held. A configuration input marks the last program word, and fetches beyond it run as no-ops. A debug port shows the phase, program counter, address bus, data bus, opcode and argument registers, accumulator and the carry, zero and negative flags.

Top module: `acc4_cpu`

## Requirements
- R1: While reset is high at a clock edge, the program counter, accumulator, opcode register, argument register, all three flags and the phase are cleared to zero. No store is performed.
- R2: A high `ld_en` writes `ld_data` to word `ld_addr` only at an edge where `rst` is high. While running, `ld_en` has no effect on memory.
- R3: The phase alternates fetch (0) and execute (1). In fetch the address bus shows the program counter. In execute it shows the argument, or the target word's low nibble for an indirect jump. The data bus always shows the memory word at the address bus.
- R4: The fetched word is split into opcode = bits 7:4 and argument = bits 3:0. Opcode 1 loads the argument and opcode 5 loads memory[argument][3:0]. Opcode bit 2 selects the memory operand for opcodes 1 to 3 and 5 to 7. Non-branching instructions advance the program counter by one, modulo 16.
- R5: Opcodes 2 and 6 add the operand to the accumulator. Opcodes 3 and 7 compute accumulator + (operand XOR 15) + 1. The accumulator keeps the low four bits of the five-bit result.
- R6: Carry takes bit 4 of an instruction's five-bit result only when that result differs from the current accumulator; otherwise it is held. The value becomes visible in the execute phase of the next instruction.
- R7: In each execute phase, zero shows (accumulator == 0) and negative shows accumulator bit 3. Both are taken from the accumulator committed by the previous instruction.
- R8: Opcode 4 writes the accumulator, zero-extended to eight bits, to the word at the argument. The write takes effect at the end of its execute phase, so later instructions read the new value.
- R9: Opcode 8 sets the program counter to the argument. Opcode 12 sets it to the low nibble of the word at the argument.
- R10: Opcodes 9, 10 and 11 set the program counter to program counter + argument (mod 16) when carry, negative or zero, respectively, is set. Otherwise the program counter advances by one.
- R11: Opcodes 0, 13, 14 and 15 do nothing but advance the program counter. A fetch from an address above `code_last` latches opcode 0 and argument 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| ld_en | input | 1 | Load-port write enable (acts during reset only) |
| ld_addr | input | 4 | Load-port word address |
| ld_data | input | 8 | Load-port word |
| code_last | input | 4 | Address of the last program word |
| dbg_phase | output | 1 | 0 = fetch, 1 = execute |
| dbg_pc | output | 4 | Program counter |
| dbg_addr | output | 4 | Address bus |
| dbg_data | output | 8 | Memory word at the address bus |
| dbg_ir | output | 4 | Opcode register |
| dbg_dr | output | 4 | Argument register |
| dbg_acc | output | 4 | Accumulator |
| dbg_c | output | 1 | Carry flag |
| dbg_z | output | 1 | Zero flag |
| dbg_n | output | 1 | Negative flag |

## Verification
Three programs run against an instruction-level model that predicts every execute phase.

The arithmetic program chains a load, an add that overflows, and a subtract that wraps to exactly sixteen. It follows these with an add of zero and a store and reload. This separates carry updates from carry holds and shows the one-instruction flag lag through taken zero and negative branches.

The branch program sets carry by overflow and takes one carry branch. It then leaves another untaken and subtracts a memory operand.

The jump program uses absolute and indirect jumps and an in-range unused opcode. It runs past `code_last` into words that would otherwise decode as instructions. Throughout, it drives the load port, so any write outside reset shows up on a later memory load.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_NOP = 4'd0;
  localparam logic [OPC_W-1:0] OP_LDI = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADI = 4'd2;
  localparam logic [OPC_W-1:0] OP_SBI = 4'd3;
  localparam logic [OPC_W-1:0] OP_STA = 4'd4;
  localparam logic [OPC_W-1:0] OP_LDM = 4'd5;
  localparam logic [OPC_W-1:0] OP_ADM = 4'd6;
  localparam logic [OPC_W-1:0] OP_SBM = 4'd7;
  localparam logic [OPC_W-1:0] OP_JMP = 4'd8;
  localparam logic [OPC_W-1:0] OP_BRC = 4'd9;
  localparam logic [OPC_W-1:0] OP_BRN = 4'd10;
  localparam logic [OPC_W-1:0] OP_BRZ = 4'd11;
  localparam logic [OPC_W-1:0] OP_JMI = 4'd12;

  // bit of the opcode that picks a memory operand for load/add/subtract
  localparam int MEM_SEL_BIT = 2;
endpackage

// File: rtl/acc4_mem.sv
module acc4_mem #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [WORD_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [WORD_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign ra_data = store[ra_addr];
  assign rb_data = store[rb_addr];
endmodule

// File: rtl/acc4_alu.sv
module acc4_alu #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W:0]   sum
);
  logic [DATA_W:0] b_ext;

  always_comb begin
    b_ext = {1'b0, (sub ? ~b : b)};
    sum   = {1'b0, a} + b_ext + {{DATA_W{1'b0}}, sub};
  end
endmodule

// File: rtl/acc4_flags.sv
module acc4_flags #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              commit,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W:0]   next_raw,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_n
);
  logic carry_pend;
  logic result_moves;

  assign result_moves = (next_raw != {1'b0, acc});

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_pend <= 1'b0;
      flag_c     <= 1'b0;
      flag_z     <= 1'b0;
      flag_n     <= 1'b0;
    end else begin
      if (sample) begin
        flag_c <= carry_pend;
        flag_z <= (acc == '0);
        flag_n <= acc[DATA_W-1];
      end
      if (commit && result_moves) carry_pend <= next_raw[DATA_W];
    end
  end

  // R6: an unchanged result leaves the pending carry alone
  a_r6_carry_hold: assert property (@(posedge clk) disable iff (rst)
    (commit && next_raw == {1'b0, acc}) |=> $stable(carry_pend));

  // R7: flags are only refreshed at the end of a fetch phase
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    commit |=> $stable({flag_c, flag_z, flag_n}));
endmodule

// File: rtl/acc4_cpu.sv
module acc4_cpu #(
  parameter int DATA_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             ld_en,
  input  logic [DATA_W-1:0]                ld_addr,
  input  logic [acc4_pkg::OPC_W+DATA_W-1:0] ld_data,
  input  logic [DATA_W-1:0]                code_last,
  output logic                             dbg_phase,
  output logic [DATA_W-1:0]                dbg_pc,
  output logic [DATA_W-1:0]                dbg_addr,
  output logic [acc4_pkg::OPC_W+DATA_W-1:0] dbg_data,
  output logic [acc4_pkg::OPC_W-1:0]       dbg_ir,
  output logic [DATA_W-1:0]                dbg_dr,
  output logic [DATA_W-1:0]                dbg_acc,
  output logic                             dbg_c,
  output logic                             dbg_z,
  output logic                             dbg_n
);
  import acc4_pkg::*;

  localparam int ADDR_W = DATA_W;
  localparam int WORD_W = OPC_W + DATA_W;

  logic              phase;
  logic [DATA_W-1:0] pc, acc, dr;
  logic [OPC_W-1:0]  ir;
  logic              flag_c, flag_z, flag_n;

  logic [ADDR_W-1:0] ra_addr, addr_bus, mem_waddr;
  logic [WORD_W-1:0] ra_data, rb_data, fetch_word, mem_wdata;
  logic              mem_we;
  logic [DATA_W-1:0] operand, target_ind;
  logic              is_sub, do_store;
  logic [DATA_W:0]   alu_sum, next_raw;
  logic [DATA_W-1:0] next_pc;

  // ---------------- memory and buses ----------------
  assign ra_addr    = phase ? dr : pc;
  assign target_ind = ra_data[DATA_W-1:0];
  assign addr_bus   = phase ? ((ir == OP_JMI) ? target_ind : dr) : pc;
  assign fetch_word = (pc > code_last) ? '0 : ra_data;

  assign mem_we    = rst ? ld_en : (phase && do_store);
  assign mem_waddr = rst ? ld_addr : dr;
  assign mem_wdata = rst ? ld_data : {{OPC_W{1'b0}}, acc};

  acc4_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .ra_addr (ra_addr),
    .ra_data (ra_data),
    .rb_addr (addr_bus),
    .rb_data (rb_data)
  );

  // ---------------- execute ----------------
  assign operand = ir[MEM_SEL_BIT] ? ra_data[DATA_W-1:0] : dr;
  assign is_sub  = (ir == OP_SBI) || (ir == OP_SBM);

  acc4_alu #(.DATA_W(DATA_W)) u_alu (
    .a   (acc),
    .b   (operand),
    .sub (is_sub),
    .sum (alu_sum)
  );

  always_comb begin
    next_raw = {1'b0, acc};
    next_pc  = pc + 1'b1;
    do_store = 1'b0;
    case (ir)
      OP_LDI, OP_LDM:                 next_raw = {1'b0, operand};
      OP_ADI, OP_ADM, OP_SBI, OP_SBM: next_raw = alu_sum;
      OP_STA:                         do_store = 1'b1;
      OP_JMP:                         next_pc  = dr;
      OP_JMI:                         next_pc  = target_ind;
      OP_BRC: if (flag_c)             next_pc  = pc + dr;
      OP_BRN: if (flag_n)             next_pc  = pc + dr;
      OP_BRZ: if (flag_z)             next_pc  = pc + dr;
      default: ;
    endcase
  end

  acc4_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .sample   (!phase),
    .commit   (phase),
    .acc      (acc),
    .next_raw (next_raw),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_n   (flag_n)
  );

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      pc    <= '0;
      acc   <= '0;
      ir    <= '0;
      dr    <= '0;
    end else if (!phase) begin
      phase <= 1'b1;
      ir    <= fetch_word[WORD_W-1:DATA_W];
      dr    <= fetch_word[DATA_W-1:0];
    end else begin
      phase <= 1'b0;
      pc    <= next_pc;
      acc   <= next_raw[DATA_W-1:0];
    end
  end

  assign dbg_phase = phase;
  assign dbg_pc    = pc;
  assign dbg_addr  = addr_bus;
  assign dbg_data  = rb_data;
  assign dbg_ir    = ir;
  assign dbg_dr    = dr;
  assign dbg_acc   = acc;
  assign dbg_c     = flag_c;
  assign dbg_z     = flag_z;
  assign dbg_n     = flag_n;

  // ---------------- assertions ----------------
  a_r3_phase_alt: assert property (@(posedge clk) disable iff (rst)
    phase |=> !phase);

  a_r3_pc_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable(pc));

  a_r8_write_only_store: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (phase && ir == OP_STA));

  a_r9_abs_jump: assert property (@(posedge clk) disable iff (rst)
    (phase && ir == OP_JMP) |=> (pc == $past(dr)));

  a_r10_untaken_carry: assert property (@(posedge clk) disable iff (rst)
    (phase && ir == OP_BRC && !flag_c) |=> (pc == $past(pc) + 1'b1));

  a_r11_nop_advance: assert property (@(posedge clk) disable iff (rst)
    (phase && ir == OP_NOP) |=> (pc == $past(pc) + 1'b1 && acc == $past(acc)));
endmodule

// File: tb/acc4_cpu_bench.sv
module acc4_cpu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] code_last = 4'd15;
  logic       dbg_phase, dbg_c, dbg_z, dbg_n;
  logic [3:0] dbg_pc, dbg_addr, dbg_ir, dbg_dr, dbg_acc;
  logic [7:0] dbg_data;

  always #2 clk = ~clk;

  acc4_cpu u_acc4_cpu (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .code_last(code_last), .dbg_phase(dbg_phase), .dbg_pc(dbg_pc),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .dbg_ir(dbg_ir), .dbg_dr(dbg_dr),
    .dbg_acc(dbg_acc), .dbg_c(dbg_c), .dbg_z(dbg_z), .dbg_n(dbg_n)
  );

  typedef struct {
    logic [3:0] pc, ir, dr, acc, addr;
    logic [7:0] data;
    logic       c, z, n;
    string      ptag, atag;
  } item_t;

  item_t      sb[$];
  int         n_tests = 0;
  int         n_fail = 0;
  logic [7:0] mm [16];
  logic [15:0] stw;
  int         tam_addr = -1;
  logic       running = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: compare every execute phase with the next expected item
  always @(negedge clk) begin
    if (running && !rst && dbg_phase) begin
      if (sb.size() == 0) begin
        chk("R3", "unexpected execute phase", 1, 0);
      end else begin
        item_t e;
        e = sb.pop_front();
        chk(e.ptag, "pc",   dbg_pc,   e.pc);
        chk("R4",   "ir",   dbg_ir,   e.ir);
        chk("R4",   "dr",   dbg_dr,   e.dr);
        chk(e.atag, "acc",  dbg_acc,  e.acc);
        chk("R3",   "addr", dbg_addr, e.addr);
        chk("R3",   "data", dbg_data, e.data);
        chk("R6",   "carry", dbg_c,   e.c);
        chk("R7",   "zero",  dbg_z,   e.z);
        chk("R7",   "neg",   dbg_n,   e.n);
      end
    end
  end

  // driver side: instruction-level model pushes one item per instruction
  task automatic predict(int steps, logic [3:0] last);
    logic [3:0] pc = '0, acc = '0;
    logic       cp = 1'b0;
    string      pt = "R1", at = "R1";
    for (int s = 0; s < steps; s++) begin
      item_t      it;
      logic [7:0] w;
      logic [3:0] op, arg, opnd, npc;
      logic [4:0] nraw;
      logic       st;
      w   = (pc > last) ? 8'h00 : mm[pc];
      op  = w[7:4];
      arg = w[3:0];
      it.pc = pc; it.ir = op; it.dr = arg; it.acc = acc;
      it.c = cp; it.z = (acc == 4'd0); it.n = acc[3];
      it.addr = (op == 4'd12) ? mm[arg][3:0] : arg;
      it.data = mm[it.addr];
      it.ptag = pt; it.atag = at;
      sb.push_back(it);
      opnd = op[2] ? mm[arg][3:0] : arg;
      nraw = {1'b0, acc};
      npc  = pc + 4'd1;
      st   = 1'b0;
      pt   = "R4";
      at   = "R5";
      case (op)
        4'd1, 4'd5: begin
          nraw = {1'b0, opnd};
          at = (op == 4'd5 && stw[arg]) ? "R8" :
               (op == 4'd5 && int'(arg) == tam_addr) ? "R2" : "R4";
        end
        4'd2, 4'd6: nraw = {1'b0, acc} + {1'b0, opnd};
        4'd3, 4'd7: nraw = {1'b0, acc} + {1'b0, opnd ^ 4'hF} + 5'd1;
        4'd4: st = 1'b1;
        4'd8: begin npc = arg; pt = "R9"; end
        4'd12: begin npc = mm[arg][3:0]; pt = "R9"; end
        4'd9: begin if (it.c) npc = pc + arg; pt = "R10"; end
        4'd10: begin if (it.n) npc = pc + arg; pt = "R10"; end
        4'd11: begin if (it.z) npc = pc + arg; pt = "R10"; end
        default: pt = "R11";
      endcase
      if (nraw != {1'b0, acc}) cp = nraw[4];
      if (st) begin
        mm[arg] = {4'h0, acc};
        stw[arg] = 1'b1;
      end
      acc = nraw[3:0];
      pc  = npc;
    end
  endtask

  task automatic load(logic [7:0] w [16], logic [3:0] last);
    rst = 1'b1;
    code_last = last;
    for (int i = 0; i < 16; i++) begin
      ld_en = 1'b1; ld_addr = 4'(i); ld_data = w[i];
      @(posedge clk); #1;
      mm[i] = w[i];
    end
    ld_en = 1'b0;
    stw = '0;
  endtask

  task automatic check_reset();
    @(posedge clk); #1;
    @(negedge clk);
    chk("R1", "reset phase", dbg_phase, 0);
    chk("R1", "reset pc",    dbg_pc,    0);
    chk("R1", "reset acc",   dbg_acc,   0);
    chk("R1", "reset ir",    dbg_ir,    0);
    chk("R1", "reset dr",    dbg_dr,    0);
    chk("R1", "reset flags", {dbg_c, dbg_z, dbg_n}, 0);
  endtask

  task automatic run(int steps, logic tamper);
    tam_addr = tamper ? 11 : -1;
    predict(steps, code_last);
    @(posedge clk); #1;
    rst = 1'b0;
    running = 1'b1;
    if (tamper) begin
      ld_en = 1'b1; ld_addr = 4'd11; ld_data = 8'h0E;
    end
    repeat (2 * steps) @(posedge clk);
    #1;
    ld_en = 1'b0;
    rst = 1'b1;
    running = 1'b0;
    chk("R3", "items left unconsumed", sb.size(), 0);
    sb.delete();
    check_reset();
  endtask

  logic [7:0] p_arith [16] = '{8'h19, 8'h29, 8'h32, 8'hB2, 8'h1F, 8'h20, 8'h4E, 8'h17,
                               8'h6E, 8'h38, 8'hA3, 8'h11, 8'h11, 8'h5F, 8'h00, 8'h0C};
  logic [7:0] p_branch [16] = '{8'h1F, 8'h21, 8'h94, 8'h00, 8'h00, 8'h00, 8'h23, 8'h95,
                                8'h7F, 8'hB3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h06};
  logic [7:0] p_jump [16] = '{8'h13, 8'h5B, 8'h83, 8'hD0, 8'hCA, 8'h92, 8'h00, 8'h00,
                              8'h00, 8'h00, 8'h07, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00};

  initial begin
    check_reset();
    load(p_arith, 4'd15);
    run(20, 1'b0);
    load(p_branch, 4'd15);
    run(20, 1'b0);
    load(p_jump, 4'd5);
    run(24, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule